// File: doc/BRIEF.md
# Thread Block Admission Dispatcher

This block sits between a queue of thread-block launch requests and a small array of processor cores. Each request names a block and says how many threads the block contains. The dispatcher places each block, whole, on a single core. A core can accept the block only when it has room for one more resident block and room for all of that block's threads. A core that holds many small blocks runs out of block slots first. A core that holds a few large blocks runs out of thread room first.

The dispatcher keeps, for every core, a count of resident blocks and resident threads. It also records the size of the block held in each resident slot. When a core reports that the block in one of its slots has finished, the dispatcher frees that slot and subtracts the stored size. A request that no core could ever hold is consumed at once and reported as rejected. A valid request that fits nowhere at the moment stays at the head of the port, with ready held low, until a completion makes room. The occupancy of every core is visible on output ports at all times.

Top module: `blk_dispatch`

## Requirements
- R1: After reset, every core reports 0 resident blocks and 0 resident threads, `asg_valid_o` and `rej_valid_o` are low, and `req_ready_o` is low whenever `req_valid_i` is low.
- R2: A request whose thread count is 0 or greater than BLK_MAX_THREADS (512) is taken in the cycle it is presented (ready high). One cycle later `rej_valid_o` pulses with its ID. No assignment is made and occupancy does not change.
- R3: A request that fits is taken in the cycle it is presented. On the next cycle `asg_valid_o` pulses with the core, slot, ID and thread count, and that core's counts have risen by one block and by the thread count.
- R4: A core holds at most MAX_BLOCKS (8) blocks. With 64-thread blocks, two cores take exactly 16 blocks (512 threads each) before admission stops.
- R5: A core holds at most MAX_THREADS (768) threads. With 256-thread blocks, each core takes exactly 3 blocks; with 512-thread blocks, each core takes exactly 1.
- R6: While no core can take a valid in-range request, `req_ready_o` stays low and no assignment or reject is issued. Once a completion frees enough room, the same request is admitted.
- R7: A completion pulse `done_i[c]` with slot `s` that names a resident slot lowers core c's counts by one block and by the size stored for that slot, one cycle later.
- R8: A completion pulse that names a slot with no resident block has no effect on any occupancy count.
- R9: Core choice is the lowest-indexed core that fits. Slot choice is the lowest-indexed free slot of that core.
- R10: An admission and a completion on the same core in the same cycle both take effect. Fit and slot choice use the counts from before that cycle's completion.
- R11: No core's block count ever exceeds MAX_BLOCKS, and no core's thread count ever exceeds MAX_THREADS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Launch request present |
| req_ready_o | output | 1 | Request taken this cycle (admitted or rejected) |
| req_id_i | input | ID_W | Block identifier |
| req_threads_i | input | REQ_W | Threads in the block |
| done_i | input | NUM_CORES | Per-core block completion pulse |
| done_slot_i | input | NUM_CORES*SLOT_W | Per-core slot of the finished block |
| asg_valid_o | output | 1 | Assignment made last cycle |
| asg_core_o | output | CORE_W | Core chosen |
| asg_slot_o | output | SLOT_W | Slot chosen on that core |
| asg_id_o | output | ID_W | ID of the assigned block |
| asg_threads_o | output | REQ_W | Thread count of the assigned block |
| rej_valid_o | output | 1 | Unschedulable request consumed last cycle |
| rej_id_o | output | ID_W | ID of the rejected block |
| occ_blocks_o | output | NUM_CORES*BLK_W | Resident block count per core |
| occ_threads_o | output | NUM_CORES*THR_W | Resident thread count per core |

## Verification
The hardest state to reach is an admission and a completion landing on the same core in the same edge, because the choice of slot must come from the counts before the completion. The bench first parks a block in slot 0 of an empty core. In one cycle it then raises a new request and that slot's completion pulse together, and checks for slot 1 and the net counts. The stall path is reached by filling both cores with equal-sized blocks for every size in a sweep. One more request is then held. The bench frees one slot on the higher core and checks that the held block lands there.

// File: rtl/blk_dispatch_pkg.sv
package blk_dispatch_pkg;
  typedef enum logic [1:0] {
    REQ_IDLE = 2'd0,
    REQ_BAD  = 2'd1,
    REQ_FIT  = 2'd2,
    REQ_WAIT = 2'd3
  } req_kind_e;
endpackage

// File: rtl/blk_dispatch_lowest.sv
module blk_dispatch_lowest #(
  parameter int N = 8,
  parameter int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/blk_dispatch_core.sv
module blk_dispatch_core #(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int REQ_W       = 11,
  localparam int SLOT_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BLK_W  = $clog2(MAX_BLOCKS + 1),
  localparam int THR_W  = $clog2(MAX_THREADS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REQ_W-1:0]  req_threads_i,
  output logic              fit_o,
  output logic [SLOT_W-1:0] free_slot_o,
  input  logic              alloc_i,
  input  logic              done_i,
  input  logic [SLOT_W-1:0] done_slot_i,
  output logic [BLK_W-1:0]  blocks_o,
  output logic [THR_W-1:0]  threads_o
);
  localparam int SUM_W = ((THR_W > REQ_W) ? THR_W : REQ_W) + 1;

  logic [MAX_BLOCKS-1:0] busy_q;
  logic [THR_W-1:0]      size_q [MAX_BLOCKS];
  logic [BLK_W-1:0]      blocks_q;
  logic [THR_W-1:0]      threads_q;
  logic                  slot_any;
  logic [SUM_W-1:0]      sum_add;
  logic                  done_hit;
  logic [THR_W-1:0]      done_size;

  blk_dispatch_lowest #(.N(MAX_BLOCKS), .W(SLOT_W)) u_free (
    .vec_i (~busy_q),
    .any_o (slot_any),
    .idx_o (free_slot_o)
  );

  assign sum_add   = SUM_W'(threads_q) + SUM_W'(req_threads_i);
  assign fit_o     = slot_any && (sum_add <= SUM_W'(MAX_THREADS));
  assign done_hit  = done_i && busy_q[done_slot_i];
  assign done_size = size_q[done_slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= '0;
      blocks_q  <= '0;
      threads_q <= '0;
      for (int i = 0; i < MAX_BLOCKS; i++) size_q[i] <= '0;
    end else begin
      // alloc slot is free and done slot is busy, so they never collide
      if (done_hit) busy_q[done_slot_i] <= 1'b0;
      if (alloc_i) begin
        busy_q[free_slot_o] <= 1'b1;
        size_q[free_slot_o] <= THR_W'(req_threads_i);
      end
      blocks_q  <= blocks_q + BLK_W'(alloc_i) - BLK_W'(done_hit);
      threads_q <= threads_q + (alloc_i ? THR_W'(req_threads_i) : '0)
                             - (done_hit ? done_size : '0);
    end
  end

  assign blocks_o  = blocks_q;
  assign threads_o = threads_q;
endmodule

// File: rtl/blk_dispatch.sv
module blk_dispatch
  import blk_dispatch_pkg::*;
#(
  parameter int NUM_CORES       = 2,
  parameter int MAX_BLOCKS      = 8,
  parameter int MAX_THREADS     = 768,
  parameter int BLK_MAX_THREADS = 512,
  parameter int REQ_W           = 11,
  parameter int ID_W            = 8,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BLK_W  = $clog2(MAX_BLOCKS + 1),
  localparam int THR_W  = $clog2(MAX_THREADS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [ID_W-1:0]             req_id_i,
  input  logic [REQ_W-1:0]            req_threads_i,
  input  logic [NUM_CORES-1:0]        done_i,
  input  logic [NUM_CORES*SLOT_W-1:0] done_slot_i,
  output logic                        asg_valid_o,
  output logic [CORE_W-1:0]           asg_core_o,
  output logic [SLOT_W-1:0]           asg_slot_o,
  output logic [ID_W-1:0]             asg_id_o,
  output logic [REQ_W-1:0]            asg_threads_o,
  output logic                        rej_valid_o,
  output logic [ID_W-1:0]             rej_id_o,
  output logic [NUM_CORES*BLK_W-1:0]  occ_blocks_o,
  output logic [NUM_CORES*THR_W-1:0]  occ_threads_o
);
  logic [NUM_CORES-1:0] fit;
  logic [SLOT_W-1:0]    free_slot [NUM_CORES];
  logic                 core_any;
  logic [CORE_W-1:0]    core_sel;
  logic                 bad;
  req_kind_e            kind;

  assign bad = (req_threads_i == '0) || (req_threads_i > REQ_W'(BLK_MAX_THREADS));

  always_comb begin
    if (!req_valid_i)  kind = REQ_IDLE;
    else if (bad)      kind = REQ_BAD;
    else if (core_any) kind = REQ_FIT;
    else               kind = REQ_WAIT;
  end

  assign req_ready_o = (kind == REQ_BAD) || (kind == REQ_FIT);

  blk_dispatch_lowest #(.N(NUM_CORES), .W(CORE_W)) u_pick (
    .vec_i (fit),
    .any_o (core_any),
    .idx_o (core_sel)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    blk_dispatch_core #(
      .MAX_BLOCKS  (MAX_BLOCKS),
      .MAX_THREADS (MAX_THREADS),
      .REQ_W       (REQ_W)
    ) u_core (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .req_threads_i (req_threads_i),
      .fit_o         (fit[c]),
      .free_slot_o   (free_slot[c]),
      .alloc_i       ((kind == REQ_FIT) && (core_sel == CORE_W'(c))),
      .done_i        (done_i[c]),
      .done_slot_i   (done_slot_i[c*SLOT_W +: SLOT_W]),
      .blocks_o      (occ_blocks_o[c*BLK_W +: BLK_W]),
      .threads_o     (occ_threads_o[c*THR_W +: THR_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asg_valid_o   <= 1'b0;
      asg_core_o    <= '0;
      asg_slot_o    <= '0;
      asg_id_o      <= '0;
      asg_threads_o <= '0;
      rej_valid_o   <= 1'b0;
      rej_id_o      <= '0;
    end else begin
      asg_valid_o <= (kind == REQ_FIT);
      rej_valid_o <= (kind == REQ_BAD);
      if (kind == REQ_FIT) begin
        asg_core_o    <= core_sel;
        asg_slot_o    <= free_slot[core_sel];
        asg_id_o      <= req_id_i;
        asg_threads_o <= req_threads_i;
      end
      if (kind == REQ_BAD) rej_id_o <= req_id_i;
    end
  end
endmodule

// File: rtl/blk_dispatch_chk.sv
module blk_dispatch_chk #(
  parameter int NUM_CORES       = 2,
  parameter int MAX_BLOCKS      = 8,
  parameter int MAX_THREADS     = 768,
  parameter int BLK_MAX_THREADS = 512,
  parameter int REQ_W           = 11,
  parameter int ID_W            = 8,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SLOT_W = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BLK_W  = $clog2(MAX_BLOCKS + 1),
  localparam int THR_W  = $clog2(MAX_THREADS + 1)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        req_valid_i,
  input logic                        req_ready_o,
  input logic [ID_W-1:0]             req_id_i,
  input logic [REQ_W-1:0]            req_threads_i,
  input logic [NUM_CORES-1:0]        done_i,
  input logic                        asg_valid_o,
  input logic [CORE_W-1:0]           asg_core_o,
  input logic [REQ_W-1:0]            asg_threads_o,
  input logic                        rej_valid_o,
  input logic [ID_W-1:0]             rej_id_o,
  input logic [NUM_CORES*BLK_W-1:0]  occ_blocks_o,
  input logic [NUM_CORES*THR_W-1:0]  occ_threads_o
);
  logic out_of_range;
  assign out_of_range = (req_threads_i == '0) || (req_threads_i > REQ_W'(BLK_MAX_THREADS));

  assert_idle_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !req_ready_o);

  assert_reject_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && out_of_range) |=> (rej_valid_o && !asg_valid_o && rej_id_o == $past(req_id_i)));

  assert_asg_size_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asg_valid_o |-> (asg_threads_o != '0 && asg_threads_o <= REQ_W'(BLK_MAX_THREADS)));

  assert_one_outcome_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(asg_valid_o && rej_valid_o));

  assert_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> (!asg_valid_o && !rej_valid_o));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic [BLK_W-1:0] blk;
    logic [THR_W-1:0] thr;
    assign blk = occ_blocks_o[c*BLK_W +: BLK_W];
    assign thr = occ_threads_o[c*THR_W +: THR_W];

    assert_blk_cap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      blk <= BLK_W'(MAX_BLOCKS));

    assert_thr_cap_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      thr <= THR_W'(MAX_THREADS));

    assert_occ_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && req_ready_o && !out_of_range && !done_i[c] && blk == BLK_W'(MAX_BLOCKS))
      |=> !(asg_valid_o && asg_core_o == CORE_W'(c)));
  end
endmodule

bind blk_dispatch blk_dispatch_chk #(
  .NUM_CORES       (NUM_CORES),
  .MAX_BLOCKS      (MAX_BLOCKS),
  .MAX_THREADS     (MAX_THREADS),
  .BLK_MAX_THREADS (BLK_MAX_THREADS),
  .REQ_W           (REQ_W),
  .ID_W            (ID_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_id_i      (req_id_i),
  .req_threads_i (req_threads_i),
  .done_i        (done_i),
  .asg_valid_o   (asg_valid_o),
  .asg_core_o    (asg_core_o),
  .asg_threads_o (asg_threads_o),
  .rej_valid_o   (rej_valid_o),
  .rej_id_o      (rej_id_o),
  .occ_blocks_o  (occ_blocks_o),
  .occ_threads_o (occ_threads_o)
);

// File: tb/blk_dispatch_bench.sv
module blk_dispatch_bench;
  localparam int NC = 2, MB = 8, MT = 768, BMT = 512, RW = 11, IW = 8;
  localparam int CW = 1, SW = 3, BW = 4, TW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [IW-1:0] req_id = '0;
  logic [RW-1:0] req_thr = '0;
  logic [NC-1:0] done = '0;
  logic [NC*SW-1:0] done_slot = '0;
  logic asg_valid, rej_valid;
  logic [CW-1:0] asg_core;
  logic [SW-1:0] asg_slot;
  logic [IW-1:0] asg_id, rej_id;
  logic [RW-1:0] asg_thr;
  logic [NC*BW-1:0] occ_b;
  logic [NC*TW-1:0] occ_t;

  int errors = 0, checks = 0;
  int mb [NC];
  int mt [NC];
  bit busy [NC][MB];
  int msz [NC][MB];

  always #4 clk = ~clk;

  blk_dispatch u_blk_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_id_i(req_id), .req_threads_i(req_thr), .done_i(done), .done_slot_i(done_slot),
    .asg_valid_o(asg_valid), .asg_core_o(asg_core), .asg_slot_o(asg_slot),
    .asg_id_o(asg_id), .asg_threads_o(asg_thr), .rej_valid_o(rej_valid), .rej_id_o(rej_id),
    .occ_blocks_o(occ_b), .occ_threads_o(occ_t));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_occ(input string req);
    for (int c = 0; c < NC; c++) begin
      chk(int'(occ_b[c*BW +: BW]) == mb[c], req, int'(occ_b[c*BW +: BW]), mb[c]);
      chk(int'(occ_t[c*TW +: TW]) == mt[c], req, int'(occ_t[c*TW +: TW]), mt[c]);
    end
  endtask

  function automatic int exp_core(input int thr);
    for (int c = 0; c < NC; c++)
      if (mb[c] < MB && mt[c] + thr <= MT) return c;
    return -1;
  endfunction

  function automatic int exp_slot(input int c);
    for (int s = 0; s < MB; s++) if (!busy[c][s]) return s;
    return -1;
  endfunction

  // starts and ends just after a negedge
  task automatic admit(input int id, input int thr, input string req);
    int ec, es;
    ec = exp_core(thr);
    es = (ec >= 0) ? exp_slot(ec) : -1;
    req_valid = 1'b1; req_id = IW'(id); req_thr = RW'(thr);
    #1;
    chk(req_ready == 1'b1, req, int'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(asg_valid == 1'b1, req, int'(asg_valid), 1);
    chk(int'(asg_core) == ec, req, int'(asg_core), ec);
    chk(int'(asg_slot) == es, req, int'(asg_slot), es);
    chk(int'(asg_id) == id && int'(asg_thr) == thr, req, int'(asg_id), id);
    if (ec >= 0) begin
      mb[ec]++; mt[ec] += thr; busy[ec][es] = 1'b1; msz[ec][es] = thr;
    end
    check_occ(req);
  endtask

  task automatic reject(input int id, input int thr);
    req_valid = 1'b1; req_id = IW'(id); req_thr = RW'(thr);
    #1;
    chk(req_ready == 1'b1, "R2 ready", int'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    chk(rej_valid == 1'b1 && int'(rej_id) == id, "R2 reject", int'(rej_id), id);
    chk(asg_valid == 1'b0, "R2 no assign", int'(asg_valid), 0);
    check_occ("R2 occupancy");
  endtask

  task automatic complete(input int c, input int s);
    done[c] = 1'b1; done_slot[c*SW +: SW] = SW'(s);
    @(posedge clk); @(negedge clk);
    done = '0;
    if (busy[c][s]) begin
      mb[c]--; mt[c] -= msz[c][s]; busy[c][s] = 1'b0;
      check_occ("R7 completion");
    end else begin
      check_occ("R8 free slot ignored");
    end
  endtask

  task automatic stall(input int id, input int thr);
    req_valid = 1'b1; req_id = IW'(id); req_thr = RW'(thr);
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(req_ready == 1'b0, "R6 ready low", int'(req_ready), 0);
      @(posedge clk); @(negedge clk);
      chk(!asg_valid && !rej_valid, "R6 no outcome", int'(asg_valid), 0);
    end
    req_valid = 1'b0;
    check_occ("R6 occupancy");
  endtask

  task automatic drain();
    for (int c = NC - 1; c >= 0; c--)
      for (int s = MB - 1; s >= 0; s--)
        if (busy[c][s]) complete(c, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int sizes [7] = '{64, 256, 1, 512, 100, 300, 200};
    int bads [5] = '{0, 513, 600, 1024, 2047};
    int n, per, id;
    for (int c = 0; c < NC; c++) begin
      mb[c] = 0; mt[c] = 0;
      for (int s = 0; s < MB; s++) begin busy[c][s] = 1'b0; msz[c][s] = 0; end
    end
    id = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_occ("R1 reset occupancy");
    chk(!asg_valid && !rej_valid, "R1 outputs idle", int'(asg_valid), 0);
    chk(req_ready == 1'b0, "R1 ready low when idle", int'(req_ready), 0);

    // R2 out-of-range sweep
    foreach (bads[i]) begin reject(id, bads[i]); id++; end

    // R3/R4/R5/R9 fill sweep per size, then R6 stall and release
    foreach (sizes[i]) begin
      n = 0;
      while (exp_core(sizes[i]) >= 0) begin admit(id, sizes[i], "R3 R9 admit"); id++; n++; end
      per = MT / sizes[i];
      if (per > MB) per = MB;
      chk(n == NC * per, (sizes[i] == 64) ? "R4 block limit" : "R5 thread limit", n, NC * per);
      stall(id, sizes[i]);
      complete(NC - 1, 0);
      admit(id, sizes[i], "R6 admitted after release");
      id++;
      drain();
    end

    // R9 mixed sizes, lowest free slot reuse
    admit(id, 100, "R9 mixed"); id++;
    admit(id, 300, "R9 mixed"); id++;
    admit(id, 50, "R9 mixed"); id++;
    admit(id, 200, "R9 mixed"); id++;
    admit(id, 200, "R9 spill to core 1"); id++;
    complete(0, 1);
    admit(id, 400, "R9 reuse slot 1"); id++;
    // R8 completion on an empty slot
    complete(0, 6);
    complete(1, 5);
    drain();
    complete(0, 0);

    // R10 admission and completion together on core 0
    admit(id, 100, "R10 setup"); id++;
    req_valid = 1'b1; req_id = IW'(id); req_thr = RW'(200);
    done[0] = 1'b1; done_slot[0 +: SW] = SW'(0);
    #1;
    chk(req_ready == 1'b1, "R10 ready", int'(req_ready), 1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; done = '0;
    chk(asg_valid && asg_core == 0, "R10 core", int'(asg_core), 0);
    chk(int'(asg_slot) == 1, "R10 slot", int'(asg_slot), 1);
    busy[0][0] = 1'b0; busy[0][1] = 1'b1; msz[0][1] = 200; mb[0] = 1; mt[0] = 200;
    check_occ("R10 net occupancy");
    drain();
    check_occ("R7 empty after drain");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule